// File: doc/BRIEF.md
# IDE PIO host cycle sequencer

This block is the host side of a parallel IDE-style bus for programmed I/O. Each accepted request runs one register or data transfer. The request carries the direction, a 3-bit register address, two chip-select bits, write data and a transfer mode number. The block then drives the address, the active-low chip selects, the active-low read or write strobe and the write data bus. For a read it returns the captured data with a one-cycle done pulse.

Every interval is a cycle count held in a small per-mode table covering modes 0 to 4. The intervals are address setup, strobe active width, ready decision point, recovery, hold and minimum cycle. The device ready line passes through a two-flop synchronizer. It is judged exactly once, at the decision point after the strobe goes low. A low seen there stretches the strobe until ready returns. A short dip in ready that has ended by the decision point has no effect. A wait that never ends is cut off by a timeout.

All bus pins come from registers. The pins therefore lag the internal state by one clock, and that lag is the same for every pin.

Top module: `pio_cycle_engine`

## Requirements
- R1: Synchronous active-high reset, including a reset in the middle of a transfer, puts the block idle on the next edge: bus_rd_n=1, bus_wr_n=1, bus_cs_n=2'b11, bus_d_oe=0, req_ack=0, rsp_done=0. A later request then runs normally.
- R2: In idle, a high req_valid is accepted with a one-cycle req_ack pulse. bus_cs_n carries the bitwise inverse of req_cs and bus_addr carries req_addr for exactly SETUP clock cycles before the strobe goes low.
- R3: A read drives only bus_rd_n low and a write drives only bus_wr_n low; the two are never low together. Without a wait, the strobe stays low for exactly ACTIVE cycles.
- R4: Ready may go low and return high before the decision point. In that case there is no wait and the strobe width stays ACTIVE.
- R5: The decision point uses the ready level sampled on the clock edge that lies DECIDE-3 edges after the edge that drives the strobe low (DECIDE ≥ 3, counting the two synchronizer cycles). If that level is low, the strobe is held low. It then rises on the third clock edge after the first edge that samples ready high again.
- R6: rsp_done is a one-cycle pulse at the end of each transfer, and rsp_rdata is valid with it. On a read without a wait, the data bus is captured on the last strobe-low cycle. On a waited read, it is captured on the edge where the synchronized ready is recognised high.
- R7: If ready stays low, the strobe is released after DECIDE+TMO low cycles. rsp_done then comes with rsp_timeout=1 and rsp_rdata=16'hFFFF.
- R8: After the strobe rises, chip select and address stay driven for exactly max(RECOVER, HOLD, CYCLE − strobe-low cycles) cycles.
- R9: On a write, bus_d_oe is high with the strobe and for exactly HOLD cycles after it rises, and bus_d_out holds the write data during that time. bus_d_oe is never high during a read.
- R10: Width of a transfer. In modes 0 to 2 a 16-bit transfer happens when bus_iocs16_n is low and an 8-bit one when it is high. In modes 3 and 4 bus_iocs16_n is ignored and cfg_wide picks 16 bits (1) or 8 bits (0). An 8-bit read returns zeros in bits 15:8, and an 8-bit write drives zeros there.
- R11: Default table in cycles, listed as SETUP/ACTIVE/DECIDE/RECOVER/HOLD/CYCLE: mode 0 3/8/5/5/2/18, mode 1 2/7/5/4/2/15, mode 2 2/6/4/3/1/12, mode 3 1/5/4/2/1/9, mode 4 1/4/4/2/1/7. Modes 5 to 7 use the mode 4 entry. The timeout default is TMO=24.
- R12: While the strobe is low, bus_addr and bus_cs_n do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Transfer request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mode | input | 3 | Timing mode number |
| req_addr | input | 3 | Register address |
| req_cs | input | 2 | Chip-select bits, active high |
| req_wdata | input | 16 | Write data |
| cfg_wide | input | 1 | Bus width for modes 3 and up |
| req_ack | output | 1 | Request accepted pulse |
| rsp_done | output | 1 | Transfer finished pulse |
| rsp_timeout | output | 1 | Wait cut off, valid with rsp_done |
| rsp_rdata | output | 16 | Read data, valid with rsp_done |
| bus_addr | output | 3 | Bus address |
| bus_cs_n | output | 2 | Chip selects, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_d_out | output | 16 | Data bus drive value |
| bus_d_oe | output | 1 | Data bus output enable |
| bus_d_in | input | 16 | Data bus sampled value |
| bus_rdy | input | 1 | Device ready, asynchronous |
| bus_iocs16_n | input | 1 | Device 16-bit indication, active low |

## Verification
The hardest case to reach from the ports is a dip in ready that has to be inside or outside the single decision sample, because that sample sits behind two synchronizer flops. The bench never guesses this from a free-running wave. It watches the strobe pin on falling clock edges and changes ready at counted strobe-low cycles. The glitch case releases ready at the first low sample, which is before the decision point of every mode. The wait case releases it a fixed number of cycles later, so the expected stretched width follows exactly. For the waited read, the data bus carries a junk value until ready returns. A capture made too early therefore shows up in the returned data.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int TW = 8;

  typedef struct packed {
    logic [TW-1:0] setup;
    logic [TW-1:0] act;
    logic [TW-1:0] decide;
    logic [TW-1:0] recov;
    logic [TW-1:0] hold;
    logic [TW-1:0] cyc;
  } pio_tim_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_ACTIVE, ST_WAIT, ST_RECOV
  } pio_st_t;
endpackage

// File: rtl/pio_sync2.sv
module pio_sync2 #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '1;
    else     sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/pio_mode_table.sv
module pio_mode_table
  import pio_pkg::*;
#(
  parameter int MODE_W    = 3,
  parameter int NUM_MODES = 5,
  parameter logic [NUM_MODES*TW-1:0] SETUP_TBL  = {8'd1, 8'd1, 8'd2, 8'd2, 8'd3},
  parameter logic [NUM_MODES*TW-1:0] ACT_TBL    = {8'd4, 8'd5, 8'd6, 8'd7, 8'd8},
  parameter logic [NUM_MODES*TW-1:0] DECIDE_TBL = {8'd4, 8'd4, 8'd4, 8'd5, 8'd5},
  parameter logic [NUM_MODES*TW-1:0] RECOV_TBL  = {8'd2, 8'd2, 8'd3, 8'd4, 8'd5},
  parameter logic [NUM_MODES*TW-1:0] HOLD_TBL   = {8'd1, 8'd1, 8'd1, 8'd2, 8'd2},
  parameter logic [NUM_MODES*TW-1:0] CYC_TBL    = {8'd7, 8'd9, 8'd12, 8'd15, 8'd18}
) (
  input  logic [MODE_W-1:0] mode,
  output pio_tim_t          tim
);
  localparam logic [MODE_W-1:0] TOP_MODE = MODE_W'(NUM_MODES-1);

  logic [MODE_W-1:0] idx;

  always_comb begin
    idx        = (mode > TOP_MODE) ? TOP_MODE : mode;
    tim.setup  = SETUP_TBL[idx*TW +: TW];
    tim.act    = ACT_TBL[idx*TW +: TW];
    tim.decide = DECIDE_TBL[idx*TW +: TW];
    tim.recov  = RECOV_TBL[idx*TW +: TW];
    tim.hold   = HOLD_TBL[idx*TW +: TW];
    tim.cyc    = CYC_TBL[idx*TW +: TW];
  end
endmodule

// File: rtl/pio_cycle_engine.sv
module pio_cycle_engine
  import pio_pkg::*;
#(
  parameter int A_W        = 3,
  parameter int CS_W       = 2,
  parameter int D_W        = 16,
  parameter int MODE_W     = 3,
  parameter int NARROW_MAX = 2,
  parameter int TMO        = 24,
  parameter int SYNC_STG   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [MODE_W-1:0] req_mode,
  input  logic [A_W-1:0]    req_addr,
  input  logic [CS_W-1:0]   req_cs,
  input  logic [D_W-1:0]    req_wdata,
  input  logic              cfg_wide,
  output logic              req_ack,
  output logic              rsp_done,
  output logic              rsp_timeout,
  output logic [D_W-1:0]    rsp_rdata,
  output logic [A_W-1:0]    bus_addr,
  output logic [CS_W-1:0]   bus_cs_n,
  output logic              bus_rd_n,
  output logic              bus_wr_n,
  output logic [D_W-1:0]    bus_d_out,
  output logic              bus_d_oe,
  input  logic [D_W-1:0]    bus_d_in,
  input  logic              bus_rdy,
  input  logic              bus_iocs16_n
);
  localparam int HALF = D_W / 2;
  localparam int WT_W = $clog2(TMO + 1);
  localparam logic [TW-1:0]   ONE      = TW'(1);
  localparam logic [WT_W-1:0] WT_LAST  = WT_W'(TMO - 1);

  pio_st_t           st;
  pio_tim_t          tim_lu, tim_q;
  logic [TW-1:0]     cnt, cyc, rec_len;
  logic [WT_W-1:0]   wcnt;
  logic              wr_q, wide_q, honor_q, tmo_q, rdy_s;
  logic [A_W-1:0]    addr_q;
  logic [CS_W-1:0]   cs_q;
  logic [D_W-1:0]    wdata_q, cap_data;
  logic              strobe_c, busy_c, oe_c;

  pio_mode_table #(.MODE_W(MODE_W)) u_table (
    .mode (req_mode),
    .tim  (tim_lu)
  );

  pio_sync2 #(.STAGES(SYNC_STG)) u_rdy_sync (
    .clk (clk),
    .rst (rst),
    .d   (bus_rdy),
    .q   (rdy_s)
  );

  always_comb begin
    rec_len  = (tim_q.recov > tim_q.hold) ? tim_q.recov : tim_q.hold;
    cap_data = wide_q ? bus_d_in : {{(D_W-HALF){1'b0}}, bus_d_in[HALF-1:0]};
    strobe_c = (st == ST_ACTIVE) || (st == ST_WAIT);
    busy_c   = (st != ST_IDLE);
    oe_c     = wr_q && (strobe_c || ((st == ST_RECOV) && (cnt < tim_q.hold)));
  end

  // sequencing
  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      tim_q       <= '0;
      cnt         <= '0;
      cyc         <= '0;
      wcnt        <= '0;
      wr_q        <= 1'b0;
      wide_q      <= 1'b0;
      honor_q     <= 1'b0;
      tmo_q       <= 1'b0;
      addr_q      <= '0;
      cs_q        <= '0;
      wdata_q     <= '0;
      req_ack     <= 1'b0;
      rsp_done    <= 1'b0;
      rsp_timeout <= 1'b0;
      rsp_rdata   <= '0;
    end else begin
      req_ack     <= 1'b0;
      rsp_done    <= 1'b0;
      rsp_timeout <= 1'b0;
      if (strobe_c || st == ST_RECOV) begin
        if (cyc != '1) cyc <= cyc + ONE;
      end
      case (st)
        ST_IDLE: begin
          if (req_valid) begin
            req_ack   <= 1'b1;
            tim_q     <= tim_lu;
            wr_q      <= req_write;
            addr_q    <= req_addr;
            cs_q      <= req_cs;
            wdata_q   <= req_wdata;
            honor_q   <= (req_mode <= MODE_W'(NARROW_MAX));
            tmo_q     <= 1'b0;
            rsp_rdata <= '0;
            cnt       <= '0;
            st        <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          if (cnt == tim_q.setup - ONE) begin
            wide_q <= honor_q ? !bus_iocs16_n : cfg_wide;
            cnt    <= '0;
            cyc    <= '0;
            st     <= ST_ACTIVE;
          end else begin
            cnt <= cnt + ONE;
          end
        end
        ST_ACTIVE: begin
          if (cnt == tim_q.decide - ONE && !rdy_s) begin
            wcnt <= '0;
            st   <= ST_WAIT;
          end else if (cnt == tim_q.act - ONE) begin
            if (!wr_q) rsp_rdata <= cap_data;
            cnt <= '0;
            st  <= ST_RECOV;
          end else begin
            cnt <= cnt + ONE;
          end
        end
        ST_WAIT: begin
          if (rdy_s) begin
            if (!wr_q) rsp_rdata <= cap_data;
            cnt <= '0;
            st  <= ST_RECOV;
          end else if (wcnt == WT_LAST) begin
            if (!wr_q) rsp_rdata <= '1;
            tmo_q <= 1'b1;
            cnt   <= '0;
            st    <= ST_RECOV;
          end else begin
            wcnt <= wcnt + 1'b1;
          end
        end
        ST_RECOV: begin
          if (cnt >= rec_len - ONE && cyc >= tim_q.cyc - ONE) begin
            rsp_done    <= 1'b1;
            rsp_timeout <= tmo_q;
            st          <= ST_IDLE;
          end else if (cnt != '1) begin
            cnt <= cnt + ONE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // registered bus pins
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rd_n  <= 1'b1;
      bus_wr_n  <= 1'b1;
      bus_cs_n  <= '1;
      bus_addr  <= '0;
      bus_d_oe  <= 1'b0;
      bus_d_out <= '0;
    end else begin
      bus_rd_n  <= !(strobe_c && !wr_q);
      bus_wr_n  <= !(strobe_c && wr_q);
      bus_cs_n  <= busy_c ? ~cs_q : '1;
      bus_addr  <= busy_c ? addr_q : '0;
      bus_d_oe  <= oe_c;
      if (!oe_c)       bus_d_out <= '0;
      else if (wide_q) bus_d_out <= wdata_q;
      else             bus_d_out <= {{(D_W-HALF){1'b0}}, wdata_q[HALF-1:0]};
    end
  end
endmodule

// File: rtl/pio_cycle_engine_chk.sv
module pio_cycle_engine_chk #(
  parameter int A_W  = 3,
  parameter int CS_W = 2,
  parameter int D_W  = 16
) (
  input logic            clk,
  input logic            rst,
  input logic            req_ack,
  input logic            rsp_done,
  input logic            rsp_timeout,
  input logic [D_W-1:0]  rsp_rdata,
  input logic [A_W-1:0]  bus_addr,
  input logic [CS_W-1:0] bus_cs_n,
  input logic            bus_rd_n,
  input logic            bus_wr_n,
  input logic            bus_d_oe
);
  logic strobe;
  assign strobe = !bus_rd_n || !bus_wr_n;

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    bus_rd_n || bus_wr_n); // R3
  AST_SELECT_IN_STROBE: assert property (@(posedge clk) disable iff (rst)
    strobe |-> bus_cs_n != '1); // R2
  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (rst)
    req_ack |=> !req_ack); // R2
  AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (rst)
    !bus_rd_n |-> !bus_d_oe); // R9
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done); // R6
  AST_TIMEOUT_RESULT: assert property (@(posedge clk) disable iff (rst)
    rsp_timeout |-> rsp_done && (rsp_rdata == '1 || bus_rd_n)); // R7
  AST_ADDR_STEADY: assert property (@(posedge clk) disable iff (rst)
    strobe && $past(strobe) |-> $stable(bus_addr) && $stable(bus_cs_n)); // R12
endmodule

bind pio_cycle_engine pio_cycle_engine_chk #(.A_W(A_W), .CS_W(CS_W), .D_W(D_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .req_ack     (req_ack),
  .rsp_done    (rsp_done),
  .rsp_timeout (rsp_timeout),
  .rsp_rdata   (rsp_rdata),
  .bus_addr    (bus_addr),
  .bus_cs_n    (bus_cs_n),
  .bus_rd_n    (bus_rd_n),
  .bus_wr_n    (bus_wr_n),
  .bus_d_oe    (bus_d_oe)
);

// File: tb/pio_cycle_engine_tb_top.sv
module pio_cycle_engine_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TMO_CYC    = 24;
  localparam int NVEC       = 6;

  // expected timing per mode (R11)
  localparam int T_S[5] = '{3, 2, 2, 1, 1};
  localparam int T_A[5] = '{8, 7, 6, 5, 4};
  localparam int T_D[5] = '{5, 5, 4, 4, 4};
  localparam int T_R[5] = '{5, 4, 3, 2, 2};
  localparam int T_H[5] = '{2, 2, 1, 1, 1};
  localparam int T_C[5] = '{18, 15, 12, 9, 7};

  typedef struct packed {
    logic        wr;
    logic [2:0]  mode;
    logic [2:0]  addr;
    logic [1:0]  cs;
    logic [15:0] wdata;
    logic [15:0] din;
    logic        iocs16_n;
    logic        wide;
  } vec_t;

  localparam vec_t VECS[NVEC] = '{
    '{1'b0, 3'd0, 3'd3, 2'b01, 16'h0000, 16'hA5C3, 1'b0, 1'b0},
    '{1'b1, 3'd1, 3'd7, 2'b10, 16'h1234, 16'h0000, 1'b0, 1'b0},
    '{1'b0, 3'd2, 3'd1, 2'b01, 16'h0000, 16'h77C3, 1'b1, 1'b1},
    '{1'b1, 3'd3, 3'd5, 2'b10, 16'hBEEF, 16'h0000, 1'b1, 1'b1},
    '{1'b0, 3'd4, 3'd2, 2'b01, 16'h0000, 16'h9A5E, 1'b0, 1'b0},
    '{1'b0, 3'd6, 3'd6, 2'b10, 16'h0000, 16'h4C1D, 1'b1, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0, cfg_wide = 1'b0;
  logic [2:0]  req_mode = '0, req_addr = '0;
  logic [1:0]  req_cs = '0;
  logic [15:0] req_wdata = '0, bus_d_in = 16'h0BAD;
  logic        bus_rdy = 1'b1, bus_iocs16_n = 1'b1;
  logic        req_ack, rsp_done, rsp_timeout, bus_rd_n, bus_wr_n, bus_d_oe;
  logic [15:0] rsp_rdata, bus_d_out;
  logic [2:0]  bus_addr;
  logic [1:0]  bus_cs_n;

  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pio_cycle_engine #(.TMO(TMO_CYC)) dut_i (
    .clk, .rst, .req_valid, .req_write, .req_mode, .req_addr, .req_cs,
    .req_wdata, .cfg_wide, .req_ack, .rsp_done, .rsp_timeout, .rsp_rdata,
    .bus_addr, .bus_cs_n, .bus_rd_n, .bus_wr_n, .bus_d_out, .bus_d_oe,
    .bus_d_in, .bus_rdy, .bus_iocs16_n
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_idle(input string tag);
    chk(bus_rd_n === 1'b1 && bus_wr_n === 1'b1, tag, {bus_rd_n, bus_wr_n}, 2'b11);
    chk(bus_cs_n === 2'b11, tag, bus_cs_n, 2'b11);
    chk(bus_d_oe === 1'b0 && req_ack === 1'b0 && rsp_done === 1'b0, tag,
        {bus_d_oe, req_ack, rsp_done}, 0);
  endtask

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // rmode: 0 ready high, 1 dip released at first low sample, 2 held low w cycles, 3 stuck low
  task automatic run_xfer(input vec_t v, input int rmode, input int w, input string tag_low);
    int m, exp_low, exp_rec, setup_n, low_n, rec_n, oe_after, acks, dones, guard;
    bit phase1, rd_used, wr_used, oe_read, addr_bad, tmo_seen, wide;
    logic [15:0] dout_seen, rdata_seen, exp_data;
    setup_n = 0; low_n = 0; rec_n = 0; oe_after = 0; acks = 0; dones = 0; guard = 0;
    phase1 = 0; rd_used = 0; wr_used = 0; oe_read = 0; addr_bad = 0; tmo_seen = 0;
    dout_seen = '0; rdata_seen = '0;
    m    = (v.mode > 4) ? 4 : int'(v.mode);
    wide = (m <= 2) ? !v.iocs16_n : v.wide;
    @(negedge clk);
    req_valid = 1'b1; req_write = v.wr; req_mode = v.mode; req_addr = v.addr;
    req_cs = v.cs; req_wdata = v.wdata; cfg_wide = v.wide; bus_iocs16_n = v.iocs16_n;
    bus_d_in = (rmode == 2) ? 16'hDEAD : v.din;
    bus_rdy  = (rmode == 0);
    while (guard < 400) begin
      @(negedge clk);
      guard++;
      if (req_ack) begin acks++; req_valid = 1'b0; end
      if (rsp_done) begin dones++; rdata_seen = rsp_rdata; tmo_seen = rsp_timeout; end
      if (bus_d_oe && !v.wr) oe_read = 1;
      if (!bus_rd_n || !bus_wr_n) begin
        phase1 = 1;
        low_n++;
        if (!bus_rd_n) rd_used = 1;
        if (!bus_wr_n) wr_used = 1;
        if (v.wr && bus_d_oe) dout_seen = bus_d_out;
        if (bus_cs_n !== ~v.cs || bus_addr !== v.addr) addr_bad = 1;
        if (rmode == 1 && low_n == 1) bus_rdy = 1'b1;
        if (rmode == 2 && low_n == w + 1) begin bus_rdy = 1'b1; bus_d_in = v.din; end
      end else if (phase1) begin
        if (bus_cs_n === 2'b11) break;
        rec_n++;
        if (bus_d_oe) oe_after++;
      end else if (bus_cs_n !== 2'b11) begin
        setup_n++;
        if (bus_cs_n !== ~v.cs || bus_addr !== v.addr) addr_bad = 1;
      end
    end
    bus_rdy = 1'b1;
    bus_d_in = 16'h0BAD;
    req_valid = 1'b0;

    exp_low  = (rmode == 2) ? w + 4 : (rmode == 3) ? T_D[m] + TMO_CYC : T_A[m];
    exp_rec  = mx(mx(T_R[m], T_H[m]), T_C[m] - exp_low);
    exp_data = (rmode == 3) ? 16'hFFFF : wide ? v.din : {8'h00, v.din[7:0]};

    chk(acks == 1, "R2 ack pulses", acks, 1);
    chk(setup_n == T_S[m], "R2 R11 setup cycles", setup_n, T_S[m]);
    chk(low_n == exp_low, tag_low, low_n, exp_low);
    chk(v.wr ? (wr_used && !rd_used) : (rd_used && !wr_used), "R3 strobe line",
        {rd_used, wr_used}, v.wr ? 2'b01 : 2'b10);
    chk(rec_n == exp_rec, "R8 recovery cycles", rec_n, exp_rec);
    chk(dones == 1, "R6 done pulses", dones, 1);
    chk(!addr_bad, "R12 address and select", addr_bad, 0);
    chk(tmo_seen == (rmode == 3), "R7 timeout flag", tmo_seen, rmode == 3);
    if (!v.wr) begin
      chk(rdata_seen === exp_data, "R6 R10 read data", rdata_seen, exp_data);
      chk(!oe_read, "R9 no drive on read", oe_read, 0);
    end else begin
      chk(dout_seen === (wide ? v.wdata : {8'h00, v.wdata[7:0]}), "R9 R10 write data",
          dout_seen, wide ? v.wdata : {8'h00, v.wdata[7:0]});
      chk(oe_after == T_H[m], "R9 data hold", oe_after, T_H[m]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_idle("R1 reset state");
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    chk_idle("R1 idle after reset");

    for (int i = 0; i < NVEC; i++)
      run_xfer(VECS[i], 0, 0, "R3 R11 strobe width");

    // ready dip ended before the decision point
    run_xfer(VECS[0], 1, 0, "R4 dip ignored");
    run_xfer(VECS[4], 1, 0, "R4 dip ignored mode 4");
    // ready low across the decision point
    run_xfer(VECS[0], 2, 10, "R5 stretched read");
    run_xfer(VECS[1], 2, 6, "R5 stretched write");
    // ready never returns
    run_xfer(VECS[2], 3, 0, "R7 timeout width");

    // reset in the middle of a strobe
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_mode = 3'd0; req_addr = 3'd4; req_cs = 2'b01;
    bus_rdy = 1'b1;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (req_ack) req_valid = 1'b0;
      if (!bus_rd_n) break;
    end
    chk(bus_rd_n === 1'b0, "R1 strobe reached", bus_rd_n, 0);
    rst = 1'b1;
    @(negedge clk);
    chk_idle("R1 reset mid transfer");
    rst = 1'b0;
    @(negedge clk);
    chk_idle("R1 quiet after reset");
    run_xfer(VECS[3], 0, 0, "R1 R3 after reset");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule